// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block fronts the 8 KiB private address window that up to four CPU cores share. It splits the window into a small snoop-control register set and a set of subordinate windows. The subordinates are the per-core interrupt CPU interfaces, the interrupt distributor, the per-core timers and the per-core watchdogs. A requesting-core ID comes with every access. This ID lets the block resolve the "own core" alias pages for the CPU interface and the timer/watchdog pair to the requester.

The block serves register accesses itself. Reads return data one cycle after the request. For a subordinate access, it raises exactly one combinational select line and passes on the offset inside the selected window. An access that lands on no valid target raises a one-cycle error pulse. This covers an undefined register, a gap, and any window of an absent core. The block also fans each core's timer and watchdog interrupt lines onto fixed positions in that core's 32-line private interrupt group.

Top module: `cp_priv_decoder`

## Requirements
- R1: Writing offset 0x000 stores only bit 0 of the write data and clears all other bits. A read of 0x000 returns the stored value with rvalid_o high one cycle after the request. After reset the value is 0.
- R2: A read of offset 0x004 returns the presence mask of NUM_CORES set bits starting at bit 4, ORed with NUM_CORES-1 in the low bits. This is 0xF3 for four cores and 0x31 for two. Writes to it change nothing.
- R3: Offsets 0x008 and 0x00C read as zero. A write to 0x00C is accepted without error and leaves the control value unchanged.
- R4: Any other offset in 0x000–0x0FF reads as zero and ignores writes. err_o pulses one cycle after the request, and on a read rvalid_o also pulses.
- R5: Page 0x1xx selects the CPU interface of the requesting core. Page 0x200+0x100·i selects core i. local_addr_o carries address bits 7:0.
- R6: Page 0x600 is the requester's timer/watchdog pair, and page 0x700+0x100·i belongs to core i. Offsets 0x00–0x1F select the timer and 0x20–0x3F select the watchdog, with local_addr_o set to bits 4:0. The rest of the page is unmapped.
- R7: Any address of 0x1000 or above selects the distributor, with local_addr_o equal to the address minus 0x1000.
- R8: These accesses select nothing and pulse err_o one cycle later: an access to a gap page, to a page of an absent core, or to an alias page when the requester ID is not below NUM_CORES.
- R9: At most one select output is high at a time, and none is high without req_i.
- R10: ppi_o bit 32·i+29 follows timer_irq_i[i], and bit 32·i+30 follows wdog_irq_i[i]. All other bits are 0.
- R11: Subordinate accesses and register writes leave rvalid_o low, and a valid subordinate access leaves err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | Write enable |
| addr_i | input | 13 | Byte offset in the private window |
| wdata_i | input | 32 | Write data |
| core_id_i | input | 2 | ID of the requesting core |
| rdata_o | output | 32 | Register read data, valid with rvalid_o |
| rvalid_o | output | 1 | Register read data valid |
| err_o | output | 1 | Unmapped or undefined access pulse |
| sel_cpuif_o | output | NUM_CORES | CPU interface select, one bit per core |
| sel_dist_o | output | 1 | Distributor select |
| sel_timer_o | output | NUM_CORES | Timer select per core |
| sel_wdog_o | output | NUM_CORES | Watchdog select per core |
| local_addr_o | output | 12 | Offset inside the selected window |
| timer_irq_i | input | NUM_CORES | Timer interrupt per core |
| wdog_irq_i | input | NUM_CORES | Watchdog interrupt per core |
| ppi_o | output | 32·NUM_CORES | Private interrupt groups, 32 lines per core |

## Verification
The assertions check these properties on every cycle. Selects are mutually exclusive and stay silent without a request. Every distributor address reaches the distributor. rvalid_o and err_o only follow a request of the right kind. A control read never shows bits above bit 0. The private interrupt vector carries exactly as many active lines as the inputs. The bench's scenarios have to show the rest. This covers the alias resolution to the requester, the exact page, core and local-offset mapping, the timer/watchdog split inside a page, and the retained control value across writes to other registers. It also covers the configuration value and the absent-core gaps, using a second instance with two cores.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int CORE_W = 2;
  localparam int LOC_W  = 12;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_REGS, TGT_CPUIF, TGT_DIST, TGT_TIMER, TGT_WDOG
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [CORE_W-1:0] core;
    logic [LOC_W-1:0]  loc;
  } dec_t;
endpackage

// File: rtl/cp_addr_decode.sv
module cp_addr_decode
  import cp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CORE_W-1:0] core_id_i,
  output dec_t              dec_o
);
  localparam logic [3:0] NC        = 4'(NUM_CORES);
  localparam logic [3:0] PG_REGS   = 4'h0;
  localparam logic [3:0] PG_OWNIF  = 4'h1;
  localparam logic [3:0] PG_IF0    = 4'h2;
  localparam logic [3:0] PG_OWNTW  = 4'h6;
  localparam logic [3:0] PG_TW0    = 4'h7;

  logic [3:0] page;
  logic       own_ok;

  assign page   = addr_i[11:8];
  assign own_ok = ({2'b00, core_id_i} < NC);

  always_comb begin
    logic [3:0] idx;
    logic       hit;
    logic [CORE_W-1:0] c;
    dec_o = '{tgt: TGT_NONE, core: '0, loc: '0};
    idx = '0;
    hit = 1'b0;
    c   = '0;
    if (addr_i[12]) begin
      dec_o.tgt = TGT_DIST;
      dec_o.loc = addr_i[11:0];
    end else if (page == PG_REGS) begin
      dec_o.tgt = TGT_REGS;
      dec_o.loc = {4'h0, addr_i[7:0]};
    end else if (page == PG_OWNIF || (page >= PG_IF0 && page < PG_IF0 + NC)) begin
      idx = page - PG_IF0;
      hit = (page == PG_OWNIF) ? own_ok : 1'b1;
      c   = (page == PG_OWNIF) ? core_id_i : idx[CORE_W-1:0];
      if (hit) begin
        dec_o.tgt  = TGT_CPUIF;
        dec_o.core = c;
        dec_o.loc  = {4'h0, addr_i[7:0]};
      end
    end else if (page == PG_OWNTW || (page >= PG_TW0 && page < PG_TW0 + NC)) begin
      idx = page - PG_TW0;
      hit = ((page == PG_OWNTW) ? own_ok : 1'b1) && (addr_i[7:6] == 2'b00);
      c   = (page == PG_OWNTW) ? core_id_i : idx[CORE_W-1:0];
      if (hit) begin
        dec_o.tgt  = addr_i[5] ? TGT_WDOG : TGT_TIMER;
        dec_o.core = c;
        dec_o.loc  = {7'h00, addr_i[4:0]};
      end
    end
  end
endmodule

// File: rtl/cp_regs.sv
module cp_regs
  import cp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [7:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              bad_o
);
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_INV  = 8'h0C;
  localparam logic [DATA_W-1:0] CFG_VAL =
    DATA_W'((((1 << NUM_CORES) - 1) << 4) | (NUM_CORES - 1));

  logic              ctrl_q;
  logic [DATA_W-1:0] rd_d;
  logic              bad_d;

  always_comb begin
    rd_d  = '0;
    bad_d = 1'b0;
    unique case (off_i)
      OFF_CTRL: rd_d = {{(DATA_W-1){1'b0}}, ctrl_q};
      OFF_CFG:  rd_d = CFG_VAL;
      OFF_STAT, OFF_INV: rd_d = '0;
      default:  bad_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= 1'b0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      bad_o    <= 1'b0;
    end else begin
      rvalid_o <= acc_i && !we_i;
      bad_o    <= acc_i && bad_d;
      if (acc_i && !we_i) rdata_o <= rd_d;
      if (acc_i && we_i && off_i == OFF_CTRL) ctrl_q <= wdata_i[0];
    end
  end
endmodule

// File: rtl/cp_irq_route.sv
module cp_irq_route #(
  parameter int NUM_CORES = 4,
  parameter int TMR_LINE  = 29,
  parameter int WDG_LINE  = 30
) (
  input  logic [NUM_CORES-1:0]    timer_irq_i,
  input  logic [NUM_CORES-1:0]    wdog_irq_i,
  output logic [32*NUM_CORES-1:0] ppi_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_comb begin
      ppi_o[32*c +: 32]         = '0;
      ppi_o[32*c + TMR_LINE]    = timer_irq_i[c];
      ppi_o[32*c + WDG_LINE]    = wdog_irq_i[c];
    end
  end
endmodule

// File: rtl/cp_priv_decoder.sv
module cp_priv_decoder
  import cp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [1:0]              core_id_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    rvalid_o,
  output logic                    err_o,
  output logic [NUM_CORES-1:0]    sel_cpuif_o,
  output logic                    sel_dist_o,
  output logic [NUM_CORES-1:0]    sel_timer_o,
  output logic [NUM_CORES-1:0]    sel_wdog_o,
  output logic [11:0]             local_addr_o,
  input  logic [NUM_CORES-1:0]    timer_irq_i,
  input  logic [NUM_CORES-1:0]    wdog_irq_i,
  output logic [32*NUM_CORES-1:0] ppi_o
);
  dec_t dec;
  logic reg_acc;
  logic reg_bad;
  logic miss_q;

  cp_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .core_id_i (core_id_i),
    .dec_o     (dec)
  );

  assign reg_acc = req_i && dec.tgt == TGT_REGS;

  cp_regs #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (reg_acc),
    .we_i     (we_i),
    .off_i    (dec.loc[7:0]),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o),
    .bad_o    (reg_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) miss_q <= 1'b0;
    else         miss_q <= req_i && dec.tgt == TGT_NONE;
  end

  assign err_o        = miss_q | reg_bad;
  assign sel_dist_o   = req_i && dec.tgt == TGT_DIST;
  assign local_addr_o = dec.loc;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
    logic mine;
    assign mine           = req_i && dec.core == 2'(c);
    assign sel_cpuif_o[c] = mine && dec.tgt == TGT_CPUIF;
    assign sel_timer_o[c] = mine && dec.tgt == TGT_TIMER;
    assign sel_wdog_o[c]  = mine && dec.tgt == TGT_WDOG;
  end

  cp_irq_route #(.NUM_CORES(NUM_CORES)) u_irq (
    .timer_irq_i (timer_irq_i),
    .wdog_irq_i  (wdog_irq_i),
    .ppi_o       (ppi_o)
  );
endmodule

// File: rtl/cp_priv_decoder_chk.sv
module cp_priv_decoder_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic                    rvalid_o,
  input logic                    err_o,
  input logic [NUM_CORES-1:0]    sel_cpuif_o,
  input logic                    sel_dist_o,
  input logic [NUM_CORES-1:0]    sel_timer_o,
  input logic [NUM_CORES-1:0]    sel_wdog_o,
  input logic [NUM_CORES-1:0]    timer_irq_i,
  input logic [NUM_CORES-1:0]    wdog_irq_i,
  input logic [32*NUM_CORES-1:0] ppi_o
);
  logic [3*NUM_CORES:0] all_sel;
  assign all_sel = {sel_cpuif_o, sel_dist_o, sel_timer_o, sel_wdog_o};

  // R9
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(all_sel));
  // R9
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> all_sel == '0);
  // R7
  dist_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[ADDR_W-1]) |-> sel_dist_o);
  // R11
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i && addr_i[ADDR_W-1:8] == '0));
  // R4
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));
  // R1
  ctrl_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == '0) |=> rdata_o[DATA_W-1:1] == '0);
  // R10
  ppi_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ppi_o) == $countones({timer_irq_i, wdog_irq_i}));
endmodule

bind cp_priv_decoder cp_priv_decoder_chk #(
  .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o),
  .sel_cpuif_o(sel_cpuif_o), .sel_dist_o(sel_dist_o),
  .sel_timer_o(sel_timer_o), .sel_wdog_o(sel_wdog_o),
  .timer_irq_i(timer_irq_i), .wdog_irq_i(wdog_irq_i), .ppi_o(ppi_o)
);

// File: tb/sim_cp_priv_decoder.sv
module sim_cp_priv_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  cid = '0;
  logic [3:0]  tirq = '0, wirq = '0;

  logic [31:0]  rdata;
  logic         rvalid, err, sdist;
  logic [3:0]   scpu, stmr, swdg;
  logic [11:0]  loc;
  logic [127:0] ppi;

  logic [31:0] rdata1;
  logic        rvalid1, err1, sdist1;
  logic [1:0]  scpu1, stmr1, swdg1;
  logic [11:0] loc1;
  logic [63:0] ppi1;

  always #4 clk = ~clk;

  cp_priv_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .core_id_i(cid), .rdata_o(rdata), .rvalid_o(rvalid),
    .err_o(err), .sel_cpuif_o(scpu), .sel_dist_o(sdist), .sel_timer_o(stmr),
    .sel_wdog_o(swdg), .local_addr_o(loc), .timer_irq_i(tirq),
    .wdog_irq_i(wirq), .ppi_o(ppi));

  cp_priv_decoder #(.NUM_CORES(2)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .core_id_i(cid), .rdata_o(rdata1), .rvalid_o(rvalid1),
    .err_o(err1), .sel_cpuif_o(scpu1), .sel_dist_o(sdist1), .sel_timer_o(stmr1),
    .sel_wdog_o(swdg1), .local_addr_o(loc1), .timer_irq_i(tirq[1:0]),
    .wdog_irq_i(wirq[1:0]), .ppi_o(ppi1));

  typedef struct {
    int          due;
    logic        rv;
    logic [31:0] rd;
    logic        er;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  localparam int K_NONE = 0, K_CPU = 1, K_DIST = 2, K_TMR = 3, K_WDG = 4, K_REG = 5;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare registered results with queued expectations
  always @(posedge clk) begin
    #2;
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      check(rvalid === it.rv && err === it.er, {it.tag, " rvalid/err"}, {rvalid, err}, {it.rv, it.er});
      if (it.rv) check(rdata === it.rd, {it.tag, " rdata"}, rdata, it.rd);
    end else if (rst_n && (rvalid !== 1'b0 || err !== 1'b0)) begin
      check(1'b0, "R11 idle cycle", {rvalid, err}, 2'b00);
    end
  end

  task automatic access(input bit w, input logic [12:0] a, input logic [31:0] d,
                        input logic [1:0] id, input int kind, input int core,
                        input logic [11:0] eloc, input bit erv, input logic [31:0] erd,
                        input bit eer, input string tag);
    logic [12:0] exp_sel, act_sel;
    item_t it;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; cid = id;
    #1;
    exp_sel = '0;
    if (kind == K_CPU)  exp_sel[12 - 3 + core] = 1'b1;
    if (kind == K_DIST) exp_sel[8] = 1'b1;
    if (kind == K_TMR)  exp_sel[4 + core] = 1'b1;
    if (kind == K_WDG)  exp_sel[core] = 1'b1;
    act_sel = {scpu, sdist, stmr, swdg};
    check(act_sel === exp_sel, {tag, " select"}, act_sel, exp_sel);
    if (kind != K_NONE && kind != K_REG)
      check(loc === eloc, {tag, " local addr"}, loc, eloc);
    it = '{due: cyc + 1, rv: erv, rd: erd, er: eer, tag: tag};
    q.push_back(it);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdata === 0 && rvalid === 0 && err === 0, "R1 reset state", {rdata, rvalid, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    access(0, 13'h000, 0, 0, K_REG, 0, 0, 1, 32'h0, 0, "R1 ctrl after reset");
    access(1, 13'h000, 32'hFFFF_FFFF, 0, K_REG, 0, 0, 0, 0, 0, "R1 ctrl write all ones");
    access(0, 13'h000, 0, 2, K_REG, 0, 0, 1, 32'h1, 0, "R1 ctrl keeps bit0 only");
    access(1, 13'h00C, 32'h0, 1, K_REG, 0, 0, 0, 0, 0, "R3 invalidate write");
    access(0, 13'h000, 0, 0, K_REG, 0, 0, 1, 32'h1, 0, "R3 ctrl unchanged");
    access(0, 13'h008, 0, 0, K_REG, 0, 0, 1, 32'h0, 0, "R3 status reads zero");
    access(0, 13'h00C, 0, 0, K_REG, 0, 0, 1, 32'h0, 0, "R3 invalidate reads zero");
    access(1, 13'h004, 32'h0, 0, K_REG, 0, 0, 0, 0, 0, "R2 config write");
    access(0, 13'h004, 0, 3, K_REG, 0, 0, 1, 32'hF3, 0, "R2 config 4 cores");
    check(rdata1 === 32'h31, "R2 config 2 cores", rdata1, 32'h31);
    access(1, 13'h010, 32'h0, 0, K_REG, 0, 0, 0, 0, 1, "R4 bad write");
    access(0, 13'h000, 0, 0, K_REG, 0, 0, 1, 32'h1, 0, "R4 ctrl untouched");
    access(0, 13'h0FC, 0, 0, K_REG, 0, 0, 1, 32'h0, 1, "R4 bad read");
    access(1, 13'h000, 32'h2, 0, K_REG, 0, 0, 0, 0, 0, "R1 ctrl write 2");
    access(0, 13'h000, 0, 0, K_REG, 0, 0, 1, 32'h0, 0, "R1 ctrl cleared");
    access(0, 13'h144, 0, 2, K_CPU, 2, 12'h044, 0, 0, 0, "R5 own cpuif core2");
    access(1, 13'h1FF, 5, 0, K_CPU, 0, 12'h0FF, 0, 0, 0, "R5 own cpuif core0");
    access(0, 13'h310, 0, 3, K_CPU, 1, 12'h010, 0, 0, 0, "R5 explicit cpuif core1");
    access(0, 13'h500, 0, 0, K_CPU, 3, 12'h000, 0, 0, 0, "R5 explicit cpuif core3");
    access(0, 13'h604, 0, 1, K_TMR, 1, 12'h004, 0, 0, 0, "R6 own timer core1");
    access(1, 13'h63F, 7, 3, K_WDG, 3, 12'h01F, 0, 0, 0, "R6 own watchdog core3");
    access(0, 13'h71C, 0, 2, K_TMR, 0, 12'h01C, 0, 0, 0, "R6 timer core0");
    access(0, 13'h A20, 0, 0, K_WDG, 3, 12'h000, 0, 0, 0, "R6 watchdog core3");
    access(0, 13'h640, 0, 0, K_NONE, 0, 0, 0, 0, 1, "R6 page tail unmapped");
    access(0, 13'h1000, 0, 1, K_DIST, 0, 12'h000, 0, 0, 0, "R7 dist base");
    access(1, 13'h1ABC, 9, 2, K_DIST, 0, 12'hABC, 0, 0, 0, "R7 dist high");
    access(0, 13'hB00, 0, 0, K_NONE, 0, 0, 0, 0, 1, "R8 gap page B");
    access(0, 13'hF80, 0, 0, K_NONE, 0, 0, 0, 0, 1, "R8 gap page F");
    // two-core instance: absent core windows
    @(negedge clk);
    req = 1'b1; addr = 13'h400; cid = 0; #1;
    check({scpu1, stmr1, swdg1, sdist1} === 0, "R8 absent cpuif core2", {scpu1, stmr1, swdg1}, 0);
    addr = 13'h900; #1;
    check({scpu1, stmr1, swdg1, sdist1} === 0, "R8 absent timer core2", {scpu1, stmr1, swdg1}, 0);
    addr = 13'h100; cid = 3; #1;
    check({scpu1, stmr1, swdg1, sdist1} === 0, "R8 alias absent requester", {scpu1, stmr1, swdg1}, 0);
    @(posedge clk); #2;
    check(err1 === 1'b1, "R8 two-core err pulse", err1, 1);
    @(negedge clk);
    req = 1'b0; cid = 0;
    q.push_back('{due: cyc, rv: 0, rd: 0, er: 0, tag: "R8 drain"});
    void'(q.pop_back());
    // R9 idle: no request, no selects
    #1;
    check({scpu, sdist, stmr, swdg} === 0, "R9 idle selects", {scpu, sdist, stmr, swdg}, 0);
    // R10 interrupt routing
    tirq = 4'b0101; wirq = 4'b1000; #1;
    check(ppi === ((128'h1 << 29) | (128'h1 << 93) | (128'h1 << 126)), "R10 ppi pattern A", ppi[127:64],
          ((128'h1 << 93) | (128'h1 << 126)) >> 64);
    tirq = 4'b0010; wirq = 4'b0011; #1;
    check(ppi === ((128'h1 << 61) | (128'h1 << 30) | (128'h1 << 62)), "R10 ppi pattern B", ppi[63:0],
          (64'h1 << 61) | (64'h1 << 30) | (64'h1 << 62));
    check(ppi1 === ((64'h1 << 61) | (64'h1 << 30) | (64'h1 << 62)), "R10 ppi two-core", ppi1,
          (64'h1 << 61) | (64'h1 << 30) | (64'h1 << 62));
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule